// File: doc/BRIEF.md
# Register Window Block Transfer Sequencer

This block copies a short run of 16-bit general registers to or from data memory in answer to a single command. The registers always come from a fixed window that starts at R2 and spans up to four registers. A load fills the window from memory, and a store empties the window into memory. A load takes its starting byte address from R0 and a store takes it from R1. Words go one at a time over a memory port with a request/ready handshake. A beat completes in any cycle where both request and ready are high.

The sequencer shares the register file with the rest of the core. It uses one combinational read port and one write port. Once the last word has moved, the sequencer writes the advanced address back into the base register it used, so a following command continues where the previous one stopped. It raises `done` for exactly that write-back cycle and then returns to idle.

Top module: `regblk_mover`

## Requirements
- R1: The 3-bit `cmd_count` selects the number of words, n. A value of 0 means n = 1. Values 1 to 4 mean n equals the value. Values 5 to 7 mean n = 4.
- R2: A load (`cmd_store` = 0) reads the word at byte address R0 + 2·i into register 2 + i, for i = 0 … n−1.
- R3: A store (`cmd_store` = 1) writes register 2 + i to byte address R1 + 2·i with `mem_we` = 1, for i = 0 … n−1. No memory word outside those n addresses changes.
- R4: Words move in ascending order of register and address, with exactly one word per accepted beat (`mem_req` && `mem_ready`).
- R5: Outside the write-back cycle, the register file is written only during a load, and only in a cycle where the memory beat is accepted. That write carries `mem_rdata` into a register from 2 to 5.
- R6: In the cycle after the final beat, the base register (R0 for a load, R1 for a store) is written with its old value plus 2·n, modulo 2^16.
- R7: `done` is high for exactly one cycle per command, in the write-back cycle. `busy` drops in the next cycle.
- R8: A command presented while `busy` is high has no effect on the transfer in progress.
- R9: While `mem_req` is high and `mem_ready` is low, the request, address and direction stay unchanged into the next cycle.
- R10: After reset, and whenever idle, `busy`, `done`, `mem_req` and `rf_we` are all 0.
- R11: Registers other than the n transferred ones and the base register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted only when idle |
| cmd_store | input | 1 | 1 = store window to memory, 0 = load window from memory |
| cmd_count | input | 3 | Word count code (see R1) |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the current beat |

## Verification
The bound checker watches the rules that hold every cycle. These are the quiet idle state, the one-cycle shape of `done`, the hold of a stalled request, the rule that a register write happens only on an accepted read beat and only into the window, and the write-back target. The contents that end up in registers and memory can only be shown by the bench's scenarios. So can the count clamp, ascending order, address wrap-around and immunity to commands issued while busy. The bench sweeps direction, every count code, several base addresses (including one that wraps) and several memory stall rates.

// File: rtl/rbm_pkg.sv
// Shared types for the register window block transfer sequencer.
// Assumes: a single sequencer instance per register file.
package rbm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BASE = 2'd1,
        ST_XFER = 2'd2,
        ST_WB   = 2'd3
    } rbm_state_e;
endpackage

// File: rtl/rbm_count_norm.sv
// Maps a raw count code onto a word count from 1 to MAXN.
// Assumes: MAXN >= 1. A zero code means one word. Codes above MAXN are clamped
// when the code field is wide enough to hold them.
module rbm_count_norm #(
    parameter int CNT_W = 3,
    parameter int MAXN  = 4,
    parameter int N_W   = $clog2(MAXN + 1)
) (
    input  logic [CNT_W-1:0] raw,
    output logic [N_W-1:0]   n
);
    localparam int CODE_MAX = (1 << CNT_W) - 1;

    generate
        if (CODE_MAX > MAXN) begin : g_clamp
            // Purpose: zero becomes one, oversize codes become MAXN.
            always_comb begin
                if (raw == '0)
                    n = N_W'(1);
                else if (raw > CNT_W'(MAXN))
                    n = N_W'(MAXN);
                else
                    n = N_W'(raw);
            end
        end else begin : g_noclamp
            // Purpose: zero becomes one, other codes pass through.
            always_comb begin
                if (raw == '0)
                    n = N_W'(1);
                else
                    n = N_W'(raw);
            end
        end
    endgenerate
endmodule

// File: rtl/rbm_fsm.sv
// Sequencing state machine: idle, base fetch, word transfers, write-back.
// Assumes: last_beat is valid throughout ST_XFER. A beat completes on mem_ready.
module rbm_fsm
    import rbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       mem_ready,
    input  logic       last_beat,
    output rbm_state_e state
);
    rbm_state_e nxt;

    // Purpose: next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (cmd_valid) nxt = ST_BASE;
            ST_BASE: nxt = ST_XFER;
            ST_XFER: if (mem_ready && last_beat) nxt = ST_WB;
            ST_WB:   nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/rbm_datapath.sv
// Holds the command, the running address and the word index, and drives the
// register file and memory ports from the current state.
// Assumes: rf_rdata follows rf_raddr combinationally in the same cycle, and
// mem_rdata is valid whenever mem_ready is high on a read beat.
module rbm_datapath
    import rbm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int RA_W     = 4,
    parameter int N_W      = 3,
    parameter int WIN_BASE = 2,
    parameter int LD_REG   = 0,
    parameter int ST_REG   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rbm_state_e        state,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [N_W-1:0]    n_in,
    input  logic [DATA_W-1:0] rf_rdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              last_beat,
    output logic [RA_W-1:0]   rf_raddr,
    output logic              rf_we,
    output logic [RA_W-1:0]   rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int STEP = DATA_W / 8;

    logic              dir_q;
    logic [N_W-1:0]    n_q;
    logic [N_W-1:0]    idx_q;
    logic [DATA_W-1:0] addr_q;
    logic [RA_W-1:0]   base_idx;
    logic [RA_W-1:0]   win_idx;
    logic              beat;

    assign base_idx  = dir_q ? RA_W'(ST_REG) : RA_W'(LD_REG);
    assign win_idx   = RA_W'(WIN_BASE) + RA_W'(idx_q);
    assign beat      = (state == ST_XFER) && mem_ready;
    assign last_beat = (idx_q == (n_q - N_W'(1)));

    // Purpose: capture the command when it is accepted in idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            n_q   <= N_W'(1);
        end else if (state == ST_IDLE && cmd_valid) begin
            dir_q <= cmd_store;
            n_q   <= n_in;
        end
    end

    // Purpose: word index, cleared per command, stepped on each accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (state == ST_IDLE)
            idx_q <= '0;
        else if (beat)
            idx_q <= idx_q + N_W'(1);
    end

    // Purpose: running byte address, loaded from the base register, stepped per beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (state == ST_BASE)
            addr_q <= rf_rdata;
        else if (beat)
            addr_q <= addr_q + DATA_W'(STEP);
    end

    // Purpose: register file read index: base register first, then the window.
    always_comb begin
        rf_raddr = (state == ST_BASE) ? base_idx : win_idx;
    end

    // Purpose: register file write: load data on accepted read beats, address at the end.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = win_idx;
        rf_wdata = mem_rdata;
        if (state == ST_WB) begin
            rf_we    = 1'b1;
            rf_waddr = base_idx;
            rf_wdata = addr_q;
        end else if (beat && !dir_q) begin
            rf_we = 1'b1;
        end
    end

    // Purpose: memory request lines.
    always_comb begin
        mem_req   = (state == ST_XFER);
        mem_we    = dir_q;
        mem_addr  = addr_q;
        mem_wdata = rf_rdata;
    end
endmodule

// File: rtl/regblk_mover.sv
// Top of the register window block transfer sequencer. Moves 1..MAXN words
// between registers WIN_BASE.. and memory, then advances the base register.
// Assumes: one combinational register read port and one write port, shared
// with nothing else while busy.
module regblk_mover
    import rbm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NREG     = 16,
    parameter int CNT_W    = 3,
    parameter int MAXN     = 4,
    parameter int WIN_BASE = 2,
    parameter int LD_REG   = 0,
    parameter int ST_REG   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_store,
    input  logic [CNT_W-1:0]  cmd_count,
    output logic              busy,
    output logic              done,
    output logic [$clog2(NREG)-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [$clog2(NREG)-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int RA_W = $clog2(NREG);
    localparam int N_W  = $clog2(MAXN + 1);

    rbm_state_e     state;
    logic [N_W-1:0] n_norm;
    logic           last_beat;

    rbm_count_norm #(.CNT_W(CNT_W), .MAXN(MAXN), .N_W(N_W)) u_norm (
        .raw (cmd_count),
        .n   (n_norm)
    );

    rbm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .mem_ready (mem_ready),
        .last_beat (last_beat),
        .state     (state)
    );

    rbm_datapath #(
        .DATA_W(DATA_W), .RA_W(RA_W), .N_W(N_W),
        .WIN_BASE(WIN_BASE), .LD_REG(LD_REG), .ST_REG(ST_REG)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .cmd_valid (cmd_valid),
        .cmd_store (cmd_store),
        .n_in      (n_norm),
        .rf_rdata  (rf_rdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .last_beat (last_beat),
        .rf_raddr  (rf_raddr),
        .rf_we     (rf_we),
        .rf_waddr  (rf_waddr),
        .rf_wdata  (rf_wdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // Purpose: status outputs derived from the state.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_WB);
    end
endmodule

// File: rtl/rbm_checker.sv
// Cycle-level rules for regblk_mover, attached by bind below.
// Assumes: same parameters as the bound instance.
module rbm_checker #(
    parameter int DATA_W   = 16,
    parameter int RA_W     = 4,
    parameter int MAXN     = 4,
    parameter int WIN_BASE = 2,
    parameter int LD_REG   = 0,
    parameter int ST_REG   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              rf_we,
    input logic [RA_W-1:0]   rf_waddr,
    input logic              mem_req,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_ready
);
    // R10: idle means no traffic on any port
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we && !done));

    // R7: completion is a single-cycle pulse, followed by idle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: a stalled request is held unchanged
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: register writes outside write-back only on accepted read beats
    p_rfwe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !done) |-> (mem_req && mem_ready && !mem_we));

    // R5: such writes land inside the window
    p_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && !done) |-> (rf_waddr >= RA_W'(WIN_BASE) &&
                              rf_waddr <  RA_W'(WIN_BASE + MAXN)));

    // R6: the write-back targets a base register
    p_wb_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rf_we && (rf_waddr == RA_W'(LD_REG) || rf_waddr == RA_W'(ST_REG))));
endmodule

bind regblk_mover rbm_checker #(
    .DATA_W(DATA_W), .RA_W(RA_W), .MAXN(MAXN),
    .WIN_BASE(WIN_BASE), .LD_REG(LD_REG), .ST_REG(ST_REG)
) u_rbm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .rf_we     (rf_we),
    .rf_waddr  (rf_waddr),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ready (mem_ready)
);

// File: tb/test_regblk_mover.sv
// Sweeps direction, every count code, several bases and stall rates, and
// checks register and memory contents against arithmetic expectations.
module test_regblk_mover;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_store = 1'b0;
    logic [2:0]  cmd_count = 3'd0;
    logic        busy, done;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [15:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;

    logic [15:0] rf  [16];
    logic [15:0] mem [256];
    logic [15:0] rf0 [16];
    logic [15:0] mem0[256];

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int done_seen = 0;
    int stall_sel = 0;
    int ph = 0;

    always #10 clk = ~clk;

    regblk_mover i_regblk_mover (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
        .cmd_count(cmd_count), .busy(busy), .done(done),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[8:1]];

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[8:1]] <= mem_wdata;
    end

    always @(negedge clk) begin
        cycles = cycles + 1;
        if (done) done_seen = done_seen + 1;
        if (ph >= stall_sel) ph = 0; else ph = ph + 1;
        mem_ready = (ph == stall_sel);
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run(input logic dir, input logic [2:0] cnt, input logic [15:0] base,
                       input int stall, input logic poke, input logic [15:0] seed);
        int n;
        int wait_c;
        logic [15:0] other;
        logic [15:0] fin;
        other = base ^ 16'h0040;
        for (int k = 0; k < 256; k++) begin
            mem[k] = {k[7:0], ~k[7:0]} ^ seed;
            mem0[k] = mem[k];
        end
        for (int j = 0; j < 16; j++) begin
            rf[j] = 16'h1000 + 16'(j) * 16'h0111 + seed;
        end
        rf[0] = dir ? other : base;
        rf[1] = dir ? base : other;
        for (int j = 0; j < 16; j++) rf0[j] = rf[j];
        n = (cnt == 0) ? 1 : ((cnt > 4) ? 4 : int'(cnt));  // R1
        stall_sel = stall;
        @(negedge clk);
        done_seen = 0;
        cmd_valid = 1'b1; cmd_store = dir; cmd_count = cnt;
        @(negedge clk);
        if (poke) begin  // R8: conflicting commands held high while busy
            cmd_store = ~dir; cmd_count = 3'd7;
        end else begin
            cmd_valid = 1'b0;
        end
        wait_c = 0;
        while (!done && wait_c < 200) begin
            @(negedge clk);
            wait_c++;
        end
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 done count", 16'(done_seen), 16'd1);
        chk("R7 busy after", {15'd0, busy}, 16'd0);
        fin = base + 16'(2 * n);
        if (!dir) begin
            for (int i = 0; i < 4; i++) begin
                if (i < n)
                    chk("R2 load word", rf[2+i], mem0[8'(base[8:1] + 8'(i))]);
                else
                    chk("R11 window tail", rf[2+i], rf0[2+i]);
            end
            chk("R6 R0 advanced", rf[0], fin);
            chk("R11 R1 kept", rf[1], rf0[1]);
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (i < n)
                    chk("R3 store word", mem[8'(base[8:1] + 8'(i))], rf0[2+i]);
            end
            chk("R3 word past end", mem[8'(base[8:1] + 8'(n))], mem0[8'(base[8:1] + 8'(n))]);
            chk("R3 word before", mem[8'(base[8:1] - 8'd1)], mem0[8'(base[8:1] - 8'd1)]);
            chk("R6 R1 advanced", rf[1], fin);
            chk("R11 R0 kept", rf[0], rf0[0]);
            for (int i = 0; i < 4; i++) chk("R11 window intact", rf[2+i], rf0[2+i]);
        end
        for (int j = 6; j < 16; j++) chk("R11 other regs", rf[j], rf0[j]);
    endtask

    initial begin
        logic [15:0] bases [4];
        bases[0] = 16'h0000; bases[1] = 16'h0010;
        bases[2] = 16'h01F8; bases[3] = 16'hFFFC;
        for (int j = 0; j < 16; j++) rf[j] = 16'h0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", {15'd0, busy}, 16'd0);
        chk("R10 done", {15'd0, done}, 16'd0);
        chk("R10 mem_req", {15'd0, mem_req}, 16'd0);
        chk("R10 rf_we", {15'd0, rf_we}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 idle after release", {14'd0, busy, mem_req}, 16'd0);
        // R1..R4, R6, R8, R11 sweep; stalls exercise R9
        for (int d = 0; d < 2; d++)
            for (int c = 0; c < 8; c++)
                for (int b = 0; b < 4; b++)
                    for (int s = 0; s < 3; s++)
                        for (int p = 0; p < 2; p++)
                            run(d[0], c[2:0], bases[b], s, p[0],
                                16'(c * 16'h0313 + b * 16'h1021 + s));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule